// File: doc/BRIEF.md
# Nibble Accumulator ALU with Carry Control

This block is the arithmetic and logic stage of a small accumulator machine that works on 4-bit data. Each cycle it takes the accumulator value, one operand and the current carry flag, together with an operation code. The operand can come from a data-memory word, a working register or an immediate field. The block returns a result, a carry value and a carry-write enable. The sequencer writes the result back to the destination. It updates the carry flag only when the enable is high.

The supported operations are four add and subtract forms, three bitwise operations, increment and decrement, four rotates and a decimal adjust. Subtraction is done as addition of the inverted operand, so the carry it returns means "no borrow". A single register stage holds the outputs. A result therefore appears one clock after its inputs were presented. Register files, memory and instruction sequencing live outside this block.

Top module: `nib_alu_top`

## Requirements
- R1: A low `rst_n` at a rising clock edge sets `res_o`, `cy_o` and `cy_we_o` to 0 (synchronous active-low reset).
- R2: Outside reset, the outputs after each rising edge reflect `op_i`, `acc_i`, `opnd_i` and `cy_i` as sampled at that edge. The `op_i` codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 increment, 8 decrement, 9 rotate left, 10 rotate left through carry, 11 rotate right, 12 rotate right through carry, 13 decimal adjust. Codes 14 and 15 are reserved.
- R3: Add forms the 5-bit sum acc+opnd, and add with carry forms acc+opnd+cy_i. Bits 3..0 of the sum are the result, bit 4 is `cy_o`, and `cy_we_o`=1.
- R4: Subtract forms acc+~opnd+1, and subtract with borrow forms acc+~opnd+cy_i, both as 5-bit sums. Bits 3..0 are the result, bit 4 (1 = no borrow) is `cy_o`, and `cy_we_o`=1.
- R5: AND, OR and XOR combine acc with opnd bitwise. For these, `cy_we_o`=0 and `cy_o` equals `cy_i`.
- R6: Increment returns opnd+1 and decrement returns opnd-1, both modulo 16. For these, `cy_we_o`=0 and `cy_o` equals `cy_i`.
- R7: Plain rotate left returns {acc[2:0],acc[3]} and plain rotate right returns {acc[0],acc[3:1]}. In both, the bit that leaves the word is also `cy_o`, and `cy_we_o`=1.
- R8: Rotate left through carry returns {acc[2:0],cy_i} with `cy_o`=acc[3]. Rotate right through carry returns {cy_i,acc[3:1]} with `cy_o`=acc[0]. Both set `cy_we_o`=1.
- R9: Decimal adjust returns the low 4 bits of acc+6 with `cy_o`=1 when acc>9 or `cy_i`=1. Otherwise it returns acc with `cy_o`=0. `cy_we_o`=1 in both cases.
- R10: Reserved codes 14 and 15 return acc unchanged, with `cy_we_o`=0 and `cy_o` equal to `cy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| acc_i | input | 4 | Accumulator value |
| opnd_i | input | 4 | Operand from memory, register or immediate |
| cy_i | input | 1 | Current carry flag |
| res_o | output | 4 | Registered result |
| cy_o | output | 1 | Registered carry value |
| cy_we_o | output | 1 | Registered carry-write enable |

## Verification
A fault in the block is visible at the ports exactly one clock after the offending inputs, because no state is kept from one cycle to the next other than the output register. A subtract that returns the borrow sense instead of the no-borrow sense, or a logic or step operation that raises the write enable, shows up in `cy_o` or `cy_we_o` on that same cycle. A wrong operand inversion or a misplaced rotate bit shows up in `res_o` for a specific data pattern only. For that reason every code is swept over all accumulator, operand and carry values, and the results are compared against a model built from the requirements.

// File: rtl/nib_alu_pkg.sv
// Shared definitions for the nibble ALU: operation codes.
package nib_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_RL   = 4'd9,
        OP_RLC  = 4'd10,
        OP_RR   = 4'd11,
        OP_RRC  = 4'd12,
        OP_DAA  = 4'd13
    } op_e;

endpackage

// File: rtl/nib_alu_arith.sv
// Adder path: add, add-with-carry, subtract, subtract-with-borrow,
// increment and decrement of the operand.
// Assumes subtraction is done as addition of the inverted operand, with a
// carry-out of 1 meaning "no borrow". Step operations pass cy_in through.
module nib_alu_arith
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cy_in,
    input  op_e          op,
    output logic [W-1:0] res,
    output logic         cy_out
);
    localparam int SW = W + 1;

    logic [W-1:0]  b_eff;
    logic          ci_eff;
    logic [SW-1:0] sum;

    // Select the effective operand and carry-in, form the full-width sum.
    always_comb begin
        b_eff = (op == OP_SUB || op == OP_SBC) ? ~b : b;
        unique case (op)
            OP_ADC, OP_SBC: ci_eff = cy_in;
            OP_SUB:         ci_eff = 1'b1;
            default:        ci_eff = 1'b0;
        endcase
        sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci_eff};
    end

    // Pick the adder sum or the operand step as the result.
    always_comb begin
        unique case (op)
            OP_INC: begin
                res    = b + {{(W-1){1'b0}}, 1'b1};
                cy_out = cy_in;
            end
            OP_DEC: begin
                res    = b - {{(W-1){1'b0}}, 1'b1};
                cy_out = cy_in;
            end
            default: begin
                res    = sum[W-1:0];
                cy_out = sum[SW-1];
            end
        endcase
    end
endmodule

// File: rtl/nib_alu_logic.sv
// Bitwise path: AND, OR, XOR of accumulator and operand.
// Assumes the caller ignores the result for other codes; carry is not produced here.
module nib_alu_logic
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] res
);
    // Bitwise combine according to the code.
    always_comb begin
        unique case (op)
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a & b;
        endcase
    end
endmodule

// File: rtl/nib_alu_rot.sv
// Rotate path: plain rotates copy the leaving bit to both the far end and the
// carry; rotates through carry insert the old carry and emit the leaving bit.
// Assumes W >= 2.
module nib_alu_rot
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic         cy_in,
    input  op_e          op,
    output logic [W-1:0] res,
    output logic         cy_out
);
    localparam int MSB = W - 1;

    // Form the rotated word and the carry it emits.
    always_comb begin
        unique case (op)
            OP_RL: begin
                res    = {a[MSB-1:0], a[MSB]};
                cy_out = a[MSB];
            end
            OP_RLC: begin
                res    = {a[MSB-1:0], cy_in};
                cy_out = a[MSB];
            end
            OP_RR: begin
                res    = {a[0], a[MSB:1]};
                cy_out = a[0];
            end
            default: begin
                res    = {cy_in, a[MSB:1]};
                cy_out = a[0];
            end
        endcase
    end
endmodule

// File: rtl/nib_alu_dadj.sv
// Decimal adjust after addition: add six when the digit exceeds nine or the
// carry is set, and set the carry in that case; otherwise pass through.
// Assumes a 4-bit BCD digit width.
module nib_alu_dadj #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic         cy_in,
    output logic [W-1:0] res,
    output logic         cy_out
);
    localparam logic [W-1:0] DIGIT_MAX = W'(9);
    localparam logic [W-1:0] ADJ       = W'(6);

    logic need_adj;

    // Decide on the correction and apply it, keeping the low bits only.
    always_comb begin
        need_adj = (a > DIGIT_MAX) || cy_in;
        res      = need_adj ? a + ADJ : a;
        cy_out   = need_adj ? 1'b1 : cy_in;
    end
endmodule

// File: rtl/nib_alu_top.sv
// Nibble accumulator ALU with one output register stage.
// Selects among the adder, bitwise, rotate and decimal-adjust paths and
// produces a carry-write enable; when the enable is low, the carry output
// mirrors the carry input. Reserved codes pass the accumulator through.
// Assumes synchronous active-low reset.
module nib_alu_top
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         cy_we_o
);
    op_e          op;
    logic [W-1:0] ar_res, lg_res, rt_res, da_res;
    logic         ar_cy, rt_cy, da_cy;
    logic [W-1:0] res_d;
    logic         cy_d, we_d;

    assign op = op_e'(op_i);

    nib_alu_arith #(.W(W)) u_arith (
        .a(acc_i), .b(opnd_i), .cy_in(cy_i), .op(op),
        .res(ar_res), .cy_out(ar_cy)
    );

    nib_alu_logic #(.W(W)) u_logic (
        .a(acc_i), .b(opnd_i), .op(op), .res(lg_res)
    );

    nib_alu_rot #(.W(W)) u_rot (
        .a(acc_i), .cy_in(cy_i), .op(op), .res(rt_res), .cy_out(rt_cy)
    );

    nib_alu_dadj #(.W(W)) u_dadj (
        .a(acc_i), .cy_in(cy_i), .res(da_res), .cy_out(da_cy)
    );

    // Route the selected path and decide whether the carry is written.
    always_comb begin
        res_d = acc_i;
        cy_d  = cy_i;
        we_d  = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res_d = ar_res;
                cy_d  = ar_cy;
                we_d  = 1'b1;
            end
            OP_INC, OP_DEC: begin
                res_d = ar_res;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_d = lg_res;
            end
            OP_RL, OP_RLC, OP_RR, OP_RRC: begin
                res_d = rt_res;
                cy_d  = rt_cy;
                we_d  = 1'b1;
            end
            OP_DAA: begin
                res_d = da_res;
                cy_d  = da_cy;
                we_d  = 1'b1;
            end
            default: begin
                res_d = acc_i;
            end
        endcase
    end

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            cy_o    <= 1'b0;
            cy_we_o <= 1'b0;
        end else begin
            res_o   <= res_d;
            cy_o    <= cy_d;
            cy_we_o <= we_d;
        end
    end
endmodule

// File: rtl/nib_alu_chk.sv
// Property checker for the nibble ALU, bound to the top module.
// Relates registered outputs to the inputs sampled one edge earlier.
module nib_alu_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_i,
    input logic [W-1:0] acc_i,
    input logic [W-1:0] opnd_i,
    input logic         cy_i,
    input logic [W-1:0] res_o,
    input logic         cy_o,
    input logic         cy_we_o
);
    localparam int SW = W + 1;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !cy_o && !cy_we_o));

    p_add_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd0) |->
        ({cy_o, res_o} == SW'($past(acc_i)) + SW'($past(opnd_i)) && cy_we_o));

    p_sub_noborrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd2) |->
        (cy_o == ($past(acc_i) >= $past(opnd_i))));

    p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) >= 4'd4 && $past(op_i) <= 4'd6) |->
        (!cy_we_o && cy_o == $past(cy_i)));

    p_step_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == 4'd7 || $past(op_i) == 4'd8)) |->
        (!cy_we_o && cy_o == $past(cy_i)));

    p_rotl_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd9) |->
        (res_o[0] == cy_o && cy_o == $past(acc_i[W-1])));

    p_daa_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd13 &&
         ($past(acc_i) > W'(9) || $past(cy_i))) |-> (cy_o && cy_we_o));

    p_reserved_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) >= 4'd14) |->
        (res_o == $past(acc_i) && !cy_we_o));
endmodule

bind nib_alu_top nib_alu_chk #(.W(W)) u_chk (.*);

// File: tb/nib_alu_tb_top.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor pops and compares.
module nib_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [3:0] acc_i = '0;
    logic [3:0] opnd_i = '0;
    logic       cy_i = 1'b0;
    logic [3:0] res_o;
    logic       cy_o;
    logic       cy_we_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] exp;   // {we, cy, res}
        string      req;
        logic [3:0] op;
        logic [3:0] a;
        logic [3:0] b;
        logic       c;
    } item_t;
    item_t sb_q[$];

    nib_alu_top dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
        .opnd_i(opnd_i), .cy_i(cy_i), .res_o(res_o), .cy_o(cy_o),
        .cy_we_o(cy_we_o)
    );

    always #10 clk = ~clk;

    // Reference model written from the requirements.
    function automatic logic [5:0] model(input int op, input int a, input int b, input int c);
        int s;
        int r;
        int cy;
        int we;
        cy = c; we = 0; r = a;
        case (op)
            0:  begin s = a + b;            r = s % 16; cy = s / 16; we = 1; end
            1:  begin s = a + b + c;        r = s % 16; cy = s / 16; we = 1; end
            2:  begin s = a + (15 - b) + 1; r = s % 16; cy = s / 16; we = 1; end
            3:  begin s = a + (15 - b) + c; r = s % 16; cy = s / 16; we = 1; end
            4:  r = a & b;
            5:  r = a | b;
            6:  r = a ^ b;
            7:  r = (b + 1) % 16;
            8:  r = (b + 15) % 16;
            9:  begin r = ((a * 2) % 16) + a / 8; cy = a / 8; we = 1; end
            10: begin r = ((a * 2) % 16) + c;     cy = a / 8; we = 1; end
            11: begin r = (a % 2) * 8 + a / 2;   cy = a % 2; we = 1; end
            12: begin r = c * 8 + a / 2;         cy = a % 2; we = 1; end
            13: begin
                    we = 1;
                    if (a > 9 || c == 1) begin r = (a + 6) % 16; cy = 1; end
                    else begin r = a; cy = 0; end
                end
            default: r = a;
        endcase
        return {we[0], cy[0], r[3:0]};
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 1:           return "R3";
            2, 3:           return "R4";
            4, 5, 6:        return "R5";
            7, 8:           return "R6";
            9, 11:          return "R7";
            10, 12:         return "R8";
            13:             return "R9";
            default:        return "R10";
        endcase
    endfunction

    // Drive one operation with reset high and queue its expected outputs (R2).
    task automatic drive_op(input int op, input int a, input int b, input int c);
        item_t it;
        @(negedge clk);
        rst_n  = 1'b1;
        op_i   = op[3:0];
        acc_i  = a[3:0];
        opnd_i = b[3:0];
        cy_i   = c[0];
        it.exp = model(op, a, b, c);
        it.req = req_of(op);
        it.op = op[3:0]; it.a = a[3:0]; it.b = b[3:0]; it.c = c[0];
        sb_q.push_back(it);
    endtask

    // Hold reset low with busy inputs and expect cleared outputs (R1).
    task automatic drive_reset(input int op, input int a, input int b);
        item_t it;
        @(negedge clk);
        rst_n  = 1'b0;
        op_i   = op[3:0];
        acc_i  = a[3:0];
        opnd_i = b[3:0];
        cy_i   = 1'b1;
        it.exp = 6'b0;
        it.req = "R1";
        it.op = op[3:0]; it.a = a[3:0]; it.b = b[3:0]; it.c = 1'b1;
        sb_q.push_back(it);
    endtask

    // Monitor: compare registered outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if ({cy_we_o, cy_o, res_o} !== it.exp) begin
                    errors++;
                    $display("FAIL %s op=%0d a=%0d b=%0d c=%0d actual we/cy/res=%b/%b/%h expected %b/%b/%h",
                             it.req, it.op, it.a, it.b, it.c,
                             cy_we_o, cy_o, res_o, it.exp[5], it.exp[4], it.exp[3:0]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual cycles=%0d expected completion", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    // Stimulus: reset, exhaustive sweep of every code, reset mid-stream, corners.
    initial begin
        drive_reset(0, 15, 15);
        drive_reset(13, 12, 3);
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int c = 0; c < 2; c++) begin
                        drive_op(op, a, b, c);
                    end
                end
            end
        end
        // R1: reset in the middle of traffic clears outputs.
        drive_op(1, 15, 15, 1);
        drive_reset(1, 15, 15);
        drive_op(1, 15, 15, 1);
        // R9 corners: 9 without carry, 10 without carry, 15 with carry.
        drive_op(13, 9, 0, 0);
        drive_op(13, 10, 0, 0);
        drive_op(13, 15, 0, 1);
        // R4 corners: equal operands, borrow chain with zero carry-in.
        drive_op(2, 5, 5, 0);
        drive_op(3, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        op_i = 4'd14;
        while (sb_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule